// File: doc/BRIEF.md
# Spectrum Packet Serialiser

This block turns one finished spectrum, held in two 32-bit wide memory banks of equal depth, into a run of fixed-size byte-stream packets ready for a downstream network stack. A single-cycle launch pulse snapshots three tag values: the accumulation number, the value of a free-running master counter, and a processor load figure. The block then streams eight packets. Each packet carries a 24-byte descriptive header and then 1024 bytes read from one quarter of one bank.

Packets alternate between the two banks at each quarter of the address space, so a consumer can rebuild 64-bit channel values from matching pairs. The block drives a single read address shared by both banks and expects registered read data one cycle later. The output is a byte stream with valid/ready flow control and first-byte/last-byte markers. A launch pulse that arrives while a spectrum is still in flight is discarded and counted.

The controller has four states. ST_IDLE waits for a launch and moves to ST_HDR when one arrives. ST_HDR emits the 24 header bytes and moves to ST_DATA after the last one is accepted. ST_DATA emits the four bytes of the current word. After the fourth byte it moves to ST_GAP if more words remain in the packet. At the end of a packet it moves to ST_HDR if more packets remain, or to ST_IDLE after the eighth packet. ST_GAP lasts one cycle while the next word is read, and then always returns to ST_DATA.

Top module: `spec_pkt_tx`

## Requirements
- R1: Each packet is exactly 1048 accepted bytes: 24 header bytes, then 1024 payload bytes. `tx_sop` marks the first header byte and `tx_eop` marks the last payload byte. The byte accepted after an end byte is either the start of the next packet or nothing (valid low).
- R2: Header byte 0 is 0x53, byte 1 is 0x00, byte 3 is 0x02 (bank count), and bytes 18 to 23 are 0x00.
- R3: Header byte 2 is the packet's bank number (0 or 1). Bytes 4-5 carry the word offset into the bank and bytes 6-7 carry the bank depth (0x0400). Both are 16-bit values, most significant byte first.
- R4: A spectrum is eight packets in the order (bank 0, offset 0x000), (bank 1, 0x000), (bank 0, 0x100), (bank 1, 0x100), and so on up to (bank 1, 0x300).
- R5: Bytes 8-11 hold the accumulation number, bytes 12-15 the master counter and bytes 16-17 the load figure, each most significant byte first. All three are captured on the accepted launch cycle and are the same in all eight packets.
- R6: The payload of the packet for bank b at offset k holds words k to k+255 of bank b in increasing address order, each sent most significant byte first. `rd_addr` selects the word, and read data is taken one cycle later.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data`, `tx_sop`, `tx_eop` and `rd_addr` hold their values.
- R8: A launch in ST_IDLE starts a spectrum, and the first header byte is offered on the next cycle. A launch in any other state changes neither the stream nor its tags, and it increments `drop_count` by one (modulo 2^16).
- R9: During and after reset, `tx_valid` is low and `drop_count` is zero.
- R10: After the last byte of the eighth packet, `tx_valid` stays low until the next accepted launch. A later spectrum carries the tag values captured at its own launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse for one spectrum |
| acc_num | input | 32 | Accumulation number, captured at launch |
| master_cnt | input | 32 | Free-running master counter, captured at launch |
| load_ind | input | 16 | Load figure, captured at launch |
| rd_addr | output | 10 | Word address driven to both banks |
| bank0_rdata | input | 32 | Registered read data of bank 0 |
| bank1_rdata | input | 32 | Registered read data of bank 1 |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_sop | output | 1 | First byte of a packet |
| tx_eop | output | 1 | Last byte of a packet |
| drop_count | output | 16 | Number of discarded launches |

## Verification
The hold and sequencing properties assume a bank behaves as a registered memory. Read data must reflect `rd_addr` exactly one cycle later and stay steady while the address is held. The bench provides this with two behavioural memories that it updates on every clock edge. The properties also assume `start` is a one-cycle pulse and that the tag inputs matter only on that cycle. To make latching visible, the bench drives `start` for one cycle only and runs the master counter freely. Flow control is exercised twice: once with a pseudo-random stall pattern on `tx_ready` and once with `tx_ready` held high. A mid-spectrum launch carrying different tags checks that it is discarded.

// File: rtl/spec_pkt_pkg.sv
package spec_pkt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_GAP
    } tx_state_t;

    localparam int          HDR_BYTES   = 24;
    localparam int          HIDX_W      = $clog2(HDR_BYTES);
    localparam int          WORD_BYTES  = 4;
    localparam int          BANK_COUNT  = 2;
    localparam logic [7:0]  LABEL_SPEC  = 8'h53;

endpackage

// File: rtl/spec_hdr_mux.sv
module spec_hdr_mux
    import spec_pkt_pkg::*;
(
    input  logic [HIDX_W-1:0] idx,
    input  logic              bank,
    input  logic [15:0]       offset,
    input  logic [15:0]       depth,
    input  logic [31:0]       acc,
    input  logic [31:0]       mcnt,
    input  logic [15:0]       load,
    output logic [7:0]        hbyte
);

    // Header byte selected by position; multi-byte fields go out MSB first.
    always_comb begin
        unique case (idx)
            5'd0:    hbyte = LABEL_SPEC;
            5'd2:    hbyte = {7'd0, bank};
            5'd3:    hbyte = 8'(BANK_COUNT);
            5'd4:    hbyte = offset[15:8];
            5'd5:    hbyte = offset[7:0];
            5'd6:    hbyte = depth[15:8];
            5'd7:    hbyte = depth[7:0];
            5'd8:    hbyte = acc[31:24];
            5'd9:    hbyte = acc[23:16];
            5'd10:   hbyte = acc[15:8];
            5'd11:   hbyte = acc[7:0];
            5'd12:   hbyte = mcnt[31:24];
            5'd13:   hbyte = mcnt[23:16];
            5'd14:   hbyte = mcnt[15:8];
            5'd15:   hbyte = mcnt[7:0];
            5'd16:   hbyte = load[15:8];
            5'd17:   hbyte = load[7:0];
            default: hbyte = 8'h00;
        endcase
    end

endmodule

// File: rtl/spec_word_slicer.sv
module spec_word_slicer
    import spec_pkt_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int SEL_W = $clog2(WORD_W / 8)
) (
    input  logic              bank,
    input  logic [SEL_W-1:0]  sel,
    input  logic [WORD_W-1:0] w0,
    input  logic [WORD_W-1:0] w1,
    output logic [7:0]        pbyte
);

    logic [WORD_W-1:0] word;

    always_comb begin
        word  = bank ? w1 : w0;
        // Byte 0 of a word is its most significant byte.
        pbyte = word[8 * ((WORD_W / 8) - 1 - int'(sel)) +: 8];
    end

endmodule

// File: rtl/spec_pkt_tx.sv
module spec_pkt_tx
    import spec_pkt_pkg::*;
#(
    parameter int DEPTH       = 1024,
    parameter int CHUNK_WORDS = 256,
    parameter int DROP_W      = 16,
    localparam int ADDR_W     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       acc_num,
    input  logic [31:0]       master_cnt,
    input  logic [15:0]       load_ind,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [31:0]       bank0_rdata,
    input  logic [31:0]       bank1_rdata,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              tx_sop,
    output logic              tx_eop,
    output logic [DROP_W-1:0] drop_count
);

    localparam int NCHUNK  = DEPTH / CHUNK_WORDS;
    localparam int NPKT    = BANK_COUNT * NCHUNK;
    localparam int PKT_W   = $clog2(NPKT);
    localparam int WIDX_W  = $clog2(CHUNK_WORDS);
    localparam int SEL_W   = $clog2(WORD_BYTES);

    tx_state_t          state, state_n;
    logic [HIDX_W-1:0]  hidx;
    logic [WIDX_W-1:0]  widx;
    logic [SEL_W-1:0]   bsel;
    logic [PKT_W-1:0]   pkt;
    logic [31:0]        acc_q, mcnt_q;
    logic [15:0]        load_q;
    logic [15:0]        offset16;
    logic [7:0]         hbyte, pbyte;
    logic               fire, hdr_last, byte_last, word_last, pkt_last, bank;

    // Packet index: low bit picks the bank, upper bits pick the quarter.
    assign bank      = pkt[0];
    assign rd_addr   = {pkt[PKT_W-1:1], widx};
    assign offset16  = 16'({pkt[PKT_W-1:1], {WIDX_W{1'b0}}});
    assign fire      = tx_valid && tx_ready;
    assign hdr_last  = (hidx == HIDX_W'(HDR_BYTES - 1));
    assign byte_last = (bsel == {SEL_W{1'b1}});
    assign word_last = (widx == {WIDX_W{1'b1}});
    assign pkt_last  = (pkt == {PKT_W{1'b1}});

    spec_hdr_mux u_hdr (
        .idx    (hidx),
        .bank   (bank),
        .offset (offset16),
        .depth  (16'(DEPTH)),
        .acc    (acc_q),
        .mcnt   (mcnt_q),
        .load   (load_q),
        .hbyte  (hbyte)
    );

    spec_word_slicer #(.WORD_W(32)) u_slice (
        .bank  (bank),
        .sel   (bsel),
        .w0    (bank0_rdata),
        .w1    (bank1_rdata),
        .pbyte (pbyte)
    );

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (start) state_n = ST_HDR;
            ST_HDR:  if (fire && hdr_last) state_n = ST_DATA;
            ST_DATA: if (fire && byte_last)
                         state_n = !word_last ? ST_GAP :
                                   (pkt_last ? ST_IDLE : ST_HDR);
            ST_GAP:  state_n = ST_DATA;
            default: state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Counters, tag capture and discarded-launch count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hidx       <= '0;
            widx       <= '0;
            bsel       <= '0;
            pkt        <= '0;
            acc_q      <= '0;
            mcnt_q     <= '0;
            load_q     <= '0;
            drop_count <= '0;
        end else begin
            if (start && state != ST_IDLE) drop_count <= drop_count + 1'b1;
            unique case (state)
                ST_IDLE: if (start) begin
                    acc_q  <= acc_num;
                    mcnt_q <= master_cnt;
                    load_q <= load_ind;
                    hidx   <= '0;
                    widx   <= '0;
                    bsel   <= '0;
                    pkt    <= '0;
                end
                ST_HDR: if (fire) hidx <= hdr_last ? '0 : hidx + 1'b1;
                ST_DATA: if (fire) begin
                    bsel <= bsel + 1'b1;
                    if (byte_last) begin
                        widx <= widx + 1'b1;
                        if (word_last) pkt <= pkt + 1'b1;
                    end
                end
                ST_GAP: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        tx_valid = 1'b0;
        tx_data  = 8'h00;
        tx_sop   = 1'b0;
        tx_eop   = 1'b0;
        unique case (state)
            ST_HDR: begin
                tx_valid = 1'b1;
                tx_data  = hbyte;
                tx_sop   = (hidx == '0);
            end
            ST_DATA: begin
                tx_valid = 1'b1;
                tx_data  = pbyte;
                tx_eop   = byte_last && word_last;
            end
            ST_IDLE, ST_GAP: ;
            default: ;
        endcase
    end

    // Stalled output and read address are frozen.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) &&
            $stable(tx_sop) && $stable(tx_eop) && $stable(rd_addr)));

    // After an end byte is taken, only a new packet start or silence follows.
    assert_pkt_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_eop) |=> (!tx_valid || tx_sop));

    // Every packet opens with the label byte.
    assert_label_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sop |-> (tx_valid && tx_data == LABEL_SPEC));

    // An idle launch offers the first header byte on the next cycle.
    assert_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state == ST_IDLE) |=> (tx_valid && tx_sop));

    // A launch during transmission bumps the discard count by one.
    assert_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && tx_valid) |=> (drop_count == $past(drop_count) + 1'b1));

    // The read-gap cycle is always followed by a payload byte.
    assert_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |=> (tx_valid && !tx_sop));

endmodule

// File: tb/spec_pkt_tx_tb_top.sv
`timescale 1ns/1ps
module spec_pkt_tx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] acc_num = '0;
    logic [31:0] master_cnt = 32'hA173_C200;
    logic [15:0] load_ind = '0;
    logic [9:0]  rd_addr;
    logic [31:0] b0_q = '0, b1_q = '0;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_sop, tx_eop;
    logic        tx_ready = 1'b0;
    logic [15:0] drop_count;

    logic [31:0] mem0 [1024];
    logic [31:0] mem1 [1024];

    logic [7:0] exp_d [$];
    logic       exp_s [$];
    logic       exp_e [$];
    string      exp_t [$];

    int  total = 0, bad = 0, sop_seen = 0, cycles = 0;
    bit  rnd_mode = 1'b0, prev_stall = 1'b0, done = 1'b0;
    logic [7:0] prev_d = '0;

    always #2.5 clk = ~clk;

    spec_pkt_tx dut_i (
        .clk, .rst_n, .start, .acc_num, .master_cnt, .load_ind,
        .rd_addr, .bank0_rdata(b0_q), .bank1_rdata(b1_q),
        .tx_data, .tx_valid, .tx_ready, .tx_sop, .tx_eop, .drop_count
    );

    // Registered memories with one cycle of read latency; free-running counter.
    always @(posedge clk) begin
        b0_q       <= mem0[rd_addr];
        b1_q       <= mem1[rd_addr];
        master_cnt <= master_cnt + 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic s, input logic e, input string t);
        exp_d.push_back(d); exp_s.push_back(s); exp_e.push_back(e); exp_t.push_back(t);
    endtask

    // Expected stream for one spectrum, built from the requirements.
    task automatic build(input logic [31:0] acc, input logic [31:0] mc, input logic [15:0] ld);
        for (int p = 0; p < 8; p++) begin
            logic [7:0]  h [24];
            logic [15:0] off;
            int          bk;
            bk  = p % 2;
            off = 16'((p / 2) * 256);
            foreach (h[i]) h[i] = 8'h00;
            h[0] = 8'h53; h[2] = 8'(bk); h[3] = 8'h02;
            h[4] = off[15:8]; h[5] = off[7:0]; h[6] = 8'h04; h[7] = 8'h00;
            for (int i = 0; i < 4; i++) begin
                h[8 + i]  = acc[31 - 8 * i -: 8];
                h[12 + i] = mc[31 - 8 * i -: 8];
            end
            h[16] = ld[15:8]; h[17] = ld[7:0];
            for (int i = 0; i < 24; i++)
                push(h[i], i == 0, 1'b0,
                     (i == 2 || i == 4 || i == 5) ? "R4" :
                     (i == 6 || i == 7)           ? "R3" :
                     (i >= 8 && i <= 17)          ? "R5" : "R2");
            for (int w = 0; w < 256; w++) begin
                logic [31:0] word;
                word = (bk == 1) ? mem1[int'(off) + w] : mem0[int'(off) + w];
                for (int b = 0; b < 4; b++)
                    push(word[31 - 8 * b -: 8], 1'b0, (w == 255 && b == 3), "R6");
            end
        end
    endtask

    // Reference comparison every cycle, away from the active edge.
    always @(negedge clk) begin
        logic r;
        cycles++;
        r = rst_n && (rnd_mode ? (($urandom % 4) != 0) : 1'b1);
        if (rst_n) begin
            if (prev_stall)
                chk(tx_valid && tx_data == prev_d, "R7", {tx_valid, tx_data}, {1'b1, prev_d});
            if (tx_valid && r) begin
                if (exp_d.size() == 0) begin
                    chk(1'b0, "R10", tx_data, 0);
                end else begin
                    logic [7:0] ed;
                    logic       es, ee;
                    string      et;
                    ed = exp_d.pop_front(); es = exp_s.pop_front();
                    ee = exp_e.pop_front(); et = exp_t.pop_front();
                    chk(tx_data == ed, et, tx_data, ed);
                    chk(tx_sop == es && tx_eop == ee, "R1", {tx_sop, tx_eop}, {es, ee});
                    if (tx_sop) sop_seen++;
                end
            end
            prev_stall = tx_valid && !r;
            prev_d     = tx_data;
        end
        tx_ready = r;
    end

    task automatic launch(input logic [31:0] acc, input logic [15:0] ld);
        @(negedge clk);
        start = 1'b1; acc_num = acc; load_ind = ld;
        build(acc, master_cnt, ld);
        @(negedge clk);
        start = 1'b0; acc_num = 32'hFFFF_FFFF; load_ind = 16'hFFFF;
    endtask

    task automatic idle_check(input int n);
        bit quiet;
        quiet = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tx_valid) quiet = 1'b0;
        end
        chk(quiet && exp_d.size() == 0, "R10", {quiet, 32'(exp_d.size())}, 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem0[i] = (i * 32'h0001_0003) ^ 32'h5A00_0000;
            mem1[i] = ~(i * 32'h0007_0001);
        end
        repeat (4) @(negedge clk);
        chk(!tx_valid, "R9", tx_valid, 0);
        chk(drop_count == 16'd0, "R9", drop_count, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!tx_valid && drop_count == 16'd0, "R9", {tx_valid, drop_count}, 0);

        // Spectrum under random back-pressure.
        rnd_mode = 1'b1;
        launch(32'h0000_4CFE, 16'h044C);
        repeat (3000) @(negedge clk);
        begin
            logic [15:0] d0;
            d0 = drop_count;
            start = 1'b1; acc_num = 32'hDEAD_BEEF; load_ind = 16'h1234;
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            chk(drop_count == d0 + 16'd1, "R8", drop_count, d0 + 16'd1);
        end
        while (exp_d.size() != 0) @(negedge clk);
        idle_check(40);
        chk(sop_seen == 8, "R4", sop_seen, 8);

        // Next spectrum, ready held high, fresh tags.
        rnd_mode = 1'b0;
        launch(32'h0000_4CFF, 16'h0001);
        while (exp_d.size() != 0) @(negedge clk);
        idle_check(40);
        chk(sop_seen == 16, "R4", sop_seen, 16);
        chk(drop_count == 16'd1, "R8", drop_count, 1);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", cycles, 0);
        finish_run();
    end

endmodule